// File: doc/BRIEF.md
# Embedded Timing Code Video Receiver

This block takes a multiplexed 4:2:2 YCbCr video stream, eight or ten bits per sample on one bus clocked by a single sample clock, and recovers all line, frame and field timing from the reference codes carried inside the data. No separate sync or blanking wires are needed. Every line carries one start-of-active code and one end-of-active code. Each code is a three-word preamble followed by a timing word. The timing word holds the field, vertical-blanking and horizontal-position flags, together with four protection bits.

The receiver searches for the preamble and checks the protection bits of the timing word. It corrects any single flipped flag bit, and it drives registered horizontal, vertical and field outputs from the result. If the timing word cannot be repaired, the receiver keeps its previous outputs and raises a sticky error flag. Active-picture samples are delayed by three words, so that the preamble of an end code can still be withheld from the output. They leave the block tagged as Cb, Y or Cr. The outputs do not depend on the 525- or 625-line standard.

Top module: `tref_sync_decoder`

## Requirements
- R1: While the synchronous active-high `rst` is high, the outputs `hsyncOut`, `vsyncOut`, `fieldOut`, `codeErr` and `sampleValid` are 0 after each clock edge.
- R2: A code is a preamble of all ones, all zeros, all zeros, followed by a timing word. The timing word holds bit9=1, bit8=F, bit7=V, bit6=H and bits 5..2 = P3..P0. On the clock edge that captures the timing word, `fieldOut`, `vsyncOut` and `hsyncOut` take the F, V and H values.
- R3: The protection bits are P3=V^H, P2=F^H, P1=F^V and P0=F^V^H. A timing word with exactly one of F, V or H inverted is corrected before the outputs are updated, and `codeErr` stays 0.
- R4: A timing word with exactly one of P3..P0 inverted updates the outputs with the F, V and H bits as received, and `codeErr` stays 0.
- R5: A timing word with two bits inverted leaves `hsyncOut`, `vsyncOut` and `fieldOut` unchanged and sets `codeErr`. `codeErr` then stays 1 until reset.
- R6: A code with H=0 and V=0 starts the active period. Every later word is output on `sampleOut` with `sampleValid`=1 three clock edges after the edge that captures it. Each word carries `compTag` in the rotation Cb, Y, Cr, Y, which begins again at every start code. The encoding is 0=Cb, 1=Y, 2=Cr, and the value 3 is never used.
- R7: A code with H=1 ends the active period. No word of any code, whether preamble or timing word, is ever output with `sampleValid`=1.
- R8: A code with H=0 and V=1 does not start the active period.
- R9: When `narrowMode`=1, the two low bits are ignored when the preamble is compared. When `narrowMode`=0, a preamble word whose low bits are not as required is not part of a code.
- R10: Inside the active period, an all-ones word followed by a single all-zeros word is passed through as ordinary samples, and the tag rotation continues.
- R11: Words that do not complete a code leave `hsyncOut`, `vsyncOut` and `fieldOut` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; the bus is captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| narrowMode | input | 1 | 1: eight-bit samples in bits 9..2, low two bits ignored |
| vidIn | input | 10 | Multiplexed video sample bus |
| hsyncOut | output | 1 | H flag from the latest accepted code |
| vsyncOut | output | 1 | V flag from the latest accepted code |
| fieldOut | output | 1 | F flag from the latest accepted code |
| codeErr | output | 1 | Sticky flag for an uncorrectable timing word |
| sampleValid | output | 1 | `sampleOut` holds an active-picture sample |
| sampleOut | output | 10 | Delayed active-picture sample |
| compTag | output | 2 | Component of `sampleOut`: 0=Cb, 1=Y, 2=Cr |

## Verification
The bench flips each flag bit on its own and each protection bit on its own, and it also flips pairs of bits. A design that decodes the syndrome wrongly would drive a wrong sync level, or would raise the error flag for a word it could have repaired. A double error must leave the sync outputs frozen and must keep the flag set even after later clean codes. The bench places a partial preamble inside the active picture and ends each line with an end code, so a design that matched on too few words, or that let preamble words through as samples, would break the scoreboard's ordered Cb/Y/Cr stream. It also checks that low-bit noise on the preamble is accepted in eight-bit mode and rejected in ten-bit mode.

// File: rtl/tref_pkg.sv
package tref_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_ONES = 2'd1,
    PS_Z1   = 2'd2,
    PS_Z2   = 2'd3
  } preState_t;

  typedef enum logic [1:0] {
    TAG_CB = 2'd0,
    TAG_Y  = 2'd1,
    TAG_CR = 2'd2
  } compTag_t;

  // strobes handed from the control to the datapath
  typedef struct packed {
    logic codeHit;
    logic codeOk;
    logic fBit;
    logic vBit;
    logic hBit;
  } strobe_t;

  typedef struct packed {
    logic ok;
    logic f;
    logic v;
    logic h;
  } flags_t;

  // timing word payload: {F, V, H, P3, P2, P1, P0}
  function automatic flags_t repairFlags(input logic [6:0] tw);
    logic f, v, h;
    logic [3:0] syn;
    flags_t r;
    f = tw[6];
    v = tw[5];
    h = tw[4];
    syn = {tw[3] ^ v ^ h, tw[2] ^ f ^ h, tw[1] ^ f ^ v, tw[0] ^ f ^ v ^ h};
    r = '{ok: 1'b1, f: f, v: v, h: h};
    case (syn)
      4'b0000, 4'b0001, 4'b0010, 4'b0100, 4'b1000: ;
      4'b0111: r.f = ~f;
      4'b1011: r.v = ~v;
      4'b1101: r.h = ~h;
      default: r.ok = 1'b0;
    endcase
    return r;
  endfunction

  function automatic compTag_t phaseToTag(input logic [1:0] ph);
    case (ph)
      2'd0: return TAG_CB;
      2'd2: return TAG_CR;
      default: return TAG_Y;
    endcase
  endfunction

endpackage

// File: rtl/tref_ctrl.sv
module tref_ctrl
  import tref_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LOW_IGNORE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              narrowMode,
  input  logic [DATA_W-1:0] vidIn,
  output strobe_t           strobes
);

  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << LOW_IGNORE) - 1);
  localparam int PAY_HI = DATA_W - 2;
  localparam int PAY_LO = DATA_W - 8;

  preState_t        preState, preNext;
  logic [DATA_W-1:0] cmpMask;
  logic              isOnes, isZeros;
  flags_t            fixed;

  assign cmpMask = narrowMode ? LOW_MASK : '0;
  assign isOnes  = &(vidIn | cmpMask);
  assign isZeros = ~|(vidIn & ~cmpMask);

  always_comb begin
    preNext = PS_IDLE;
    if (isOnes) begin
      preNext = PS_ONES;
    end else begin
      case (preState)
        PS_ONES: preNext = isZeros ? PS_Z1 : PS_IDLE;
        PS_Z1:   preNext = isZeros ? PS_Z2 : PS_IDLE;
        default: preNext = PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) preState <= PS_IDLE;
    else     preState <= preNext;
  end

  assign fixed = repairFlags(vidIn[PAY_HI:PAY_LO]);

  always_comb begin
    strobes.codeHit = (preState == PS_Z2);
    strobes.codeOk  = fixed.ok;
    strobes.fBit    = fixed.f;
    strobes.vBit    = fixed.v;
    strobes.hBit    = fixed.h;
  end

  // R2: a code needs four words, so two hits are never adjacent
  a_r2_hit_spacing: assert property (@(posedge clk) disable iff (rst)
    strobes.codeHit |=> !strobes.codeHit);

  // R2: the preamble must pass through both zero states before a hit
  a_r2_hit_after_zero: assert property (@(posedge clk) disable iff (rst)
    (preState == PS_Z2) |-> $past(preState == PS_Z1));

endmodule

// File: rtl/tref_datapath.sv
module tref_datapath
  import tref_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int PIPE_D = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] vidIn,
  input  strobe_t           strobes,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              fieldOut,
  output logic              codeErr,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleOut,
  output logic [1:0]        compTag
);

  logic [DATA_W-1:0] histWord [PIPE_D];
  logic              histVld  [PIPE_D];
  compTag_t          histTag  [PIPE_D];
  logic              activeState;
  logic [1:0]        phase;

  // word history: stage 0 takes the bus, later stages shift
  genvar gi;
  generate
    for (gi = 0; gi < PIPE_D; gi++) begin : g_hist
      always_ff @(posedge clk) begin
        if (rst) begin
          histWord[gi] <= '0;
          histVld[gi]  <= 1'b0;
          histTag[gi]  <= TAG_CB;
        end else begin
          if (gi == 0) begin
            histWord[gi] <= vidIn;
            histTag[gi]  <= phaseToTag(phase);
            histVld[gi]  <= activeState && !strobes.codeHit;
          end else begin
            histWord[gi] <= histWord[gi-1];
            histTag[gi]  <= histTag[gi-1];
            histVld[gi]  <= histVld[gi-1] && !strobes.codeHit;
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleValid <= 1'b0;
      sampleOut   <= '0;
      compTag     <= TAG_CB;
    end else begin
      sampleOut   <= histWord[PIPE_D-1];
      compTag     <= histTag[PIPE_D-1];
      sampleValid <= histVld[PIPE_D-1] && !strobes.codeHit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      activeState <= 1'b0;
      phase       <= '0;
      hsyncOut    <= 1'b0;
      vsyncOut    <= 1'b0;
      fieldOut    <= 1'b0;
      codeErr     <= 1'b0;
    end else if (strobes.codeHit) begin
      if (strobes.codeOk) begin
        fieldOut <= strobes.fBit;
        vsyncOut <= strobes.vBit;
        hsyncOut <= strobes.hBit;
        if (strobes.hBit) begin
          activeState <= 1'b0;
        end else begin
          activeState <= !strobes.vBit;
          phase       <= '0;
        end
      end else begin
        codeErr <= 1'b1;
      end
    end else if (activeState) begin
      phase <= phase + 2'd1;
    end
  end

  // R1: reset clears the sync outputs, the flag and the sample strobe
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!hsyncOut && !vsyncOut && !fieldOut && !codeErr && !sampleValid));

  // R5: the error flag only clears through reset
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    codeErr |=> codeErr);

  // R5: a word that cannot be repaired leaves the sync outputs alone
  a_r5_bad_hold: assert property (@(posedge clk) disable iff (rst)
    (strobes.codeHit && !strobes.codeOk) |=> $stable({hsyncOut, vsyncOut, fieldOut}));

  // R11: sync outputs move only on a code
  a_r11_sync_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.codeHit |=> $stable({hsyncOut, vsyncOut, fieldOut}));

  // R7: the preamble word leaving the pipe at a hit is not tagged
  a_r7_no_tag_on_hit: assert property (@(posedge clk) disable iff (rst)
    strobes.codeHit |=> !sampleValid);

  // R6: the unused tag code never appears
  a_r6_tag_legal: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> (compTag != 2'd3));

  // R6: Cb is followed by Y while the stream stays valid
  a_r6_cb_then_y: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && compTag == TAG_CB) |=> (!sampleValid || compTag == TAG_Y));

endmodule

// File: rtl/tref_sync_decoder.sv
module tref_sync_decoder
  import tref_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              narrowMode,
  input  logic [DATA_W-1:0] vidIn,
  output logic              hsyncOut,
  output logic              vsyncOut,
  output logic              fieldOut,
  output logic              codeErr,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleOut,
  output logic [1:0]        compTag
);

  localparam int LOW_IGNORE = DATA_W - 8;

  strobe_t strobes;

  tref_ctrl #(.DATA_W(DATA_W), .LOW_IGNORE(LOW_IGNORE)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .narrowMode (narrowMode),
    .vidIn      (vidIn),
    .strobes    (strobes)
  );

  tref_datapath #(.DATA_W(DATA_W), .PIPE_D(3)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .vidIn       (vidIn),
    .strobes     (strobes),
    .hsyncOut    (hsyncOut),
    .vsyncOut    (vsyncOut),
    .fieldOut    (fieldOut),
    .codeErr     (codeErr),
    .sampleValid (sampleValid),
    .sampleOut   (sampleOut),
    .compTag     (compTag)
  );

endmodule

// File: tb/tref_sync_decoder_test.sv
module tref_sync_decoder_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       narrowMode = 1'b0;
  logic [9:0] vidIn = 10'h200;
  logic       hsyncOut, vsyncOut, fieldOut, codeErr, sampleValid;
  logic [9:0] sampleOut;
  logic [1:0] compTag;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [11:0] expQ [$];

  always #10 clk = ~clk;

  tref_sync_decoder uut (
    .clk(clk), .rst(rst), .narrowMode(narrowMode), .vidIn(vidIn),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .fieldOut(fieldOut),
    .codeErr(codeErr), .sampleValid(sampleValid), .sampleOut(sampleOut),
    .compTag(compTag)
  );

  function automatic logic [9:0] xyWord(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [9:0] w);
    @(negedge clk);
    vidIn = w;
  endtask

  task automatic sendSample(input logic [9:0] w, input logic [1:0] tag);
    expQ.push_back({tag, w});
    sendWord(w);
  endtask

  task automatic sendCode(input logic f, input logic v, input logic h, input logic [9:0] flip);
    sendWord(10'h3FF);
    sendWord(10'h000);
    sendWord(10'h000);
    sendWord(xyWord(f, v, h) ^ flip);
  endtask

  // sample sync state just after the edge that captures the timing word
  task automatic expectSync(input string req, input logic f, input logic v, input logic h,
                            input logic err);
    @(posedge clk);
    #2;
    check(req, {fieldOut, vsyncOut, hsyncOut, codeErr}, {f, v, h, err});
  endtask

  task automatic blank(input int n);
    for (int i = 0; i < n; i++) sendWord(10'h200);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // scoreboard monitor: each valid output must match the next expected item
  always @(posedge clk) begin
    #3;
    if (!rst && sampleValid) begin
      if (expQ.size() == 0) begin
        check("R7 unexpected sample", {compTag, sampleOut}, 12'hFFF);
      end else begin
        logic [11:0] e;
        e = expQ.pop_front();
        check("R6/R10 sample stream", {compTag, sampleOut}, e);
      end
    end
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset state", {hsyncOut, vsyncOut, fieldOut, codeErr, sampleValid}, 5'b0);
    @(negedge clk);
    rst = 1'b0;
    blank(4);

    // R2: blanking end code
    sendCode(1'b0, 1'b1, 1'b1, 10'h0);
    expectSync("R2 code decode", 1'b0, 1'b1, 1'b1, 1'b0);
    blank(3);

    // R6 start code, then a line with a partial preamble inside (R10)
    sendCode(1'b0, 1'b0, 1'b0, 10'h0);
    expectSync("R6 start code", 1'b0, 1'b0, 1'b0, 1'b0);
    sendSample(10'h200, 2'd0);
    sendSample(10'h100, 2'd1);
    sendSample(10'h210, 2'd2);
    sendSample(10'h104, 2'd1);
    sendSample(10'h3FF, 2'd0);
    sendSample(10'h000, 2'd1);
    sendSample(10'h1F0, 2'd2);
    sendSample(10'h0F0, 2'd1);
    sendSample(10'h3FF, 2'd0);
    sendSample(10'h000, 2'd1);
    sendSample(10'h3FF, 2'd2);
    sendSample(10'h120, 2'd1);
    @(posedge clk);
    #2;
    check("R11 sync held through data", {fieldOut, vsyncOut, hsyncOut}, 3'b000);

    // R7: end code closes the line, no code word is tagged
    sendCode(1'b0, 1'b0, 1'b1, 10'h0);
    expectSync("R7 end code", 1'b0, 1'b0, 1'b1, 1'b0);
    blank(6);
    check("R6 all samples delivered", expQ.size(), 0);

    // second line restarts the rotation at Cb
    sendCode(1'b1, 1'b0, 1'b0, 10'h0);
    expectSync("R6 second start", 1'b1, 1'b0, 1'b0, 1'b0);
    sendSample(10'h080, 2'd0);
    sendSample(10'h081, 2'd1);
    sendSample(10'h082, 2'd2);
    sendCode(1'b1, 1'b0, 1'b1, 10'h0);
    expectSync("R7 second end", 1'b1, 1'b0, 1'b1, 1'b0);
    blank(6);
    check("R6 second line delivered", expQ.size(), 0);

    // R3: single flag-bit errors (H is bit6, V bit7, F bit8)
    sendCode(1'b1, 1'b1, 1'b1, 10'h040);
    expectSync("R3 H bit corrected", 1'b1, 1'b1, 1'b1, 1'b0);
    blank(2);
    sendCode(1'b0, 1'b1, 1'b0, 10'h080);
    expectSync("R3 V bit corrected", 1'b0, 1'b1, 1'b0, 1'b0);
    blank(2);
    sendCode(1'b1, 1'b0, 1'b1, 10'h100);
    expectSync("R3 F bit corrected", 1'b1, 1'b0, 1'b1, 1'b0);
    blank(2);

    // R4: protection-bit errors, and R8: start code in vertical blanking
    sendCode(1'b0, 1'b1, 1'b0, 10'h004);
    expectSync("R4 P0 error", 1'b0, 1'b1, 1'b0, 1'b0);
    blank(2);
    sendCode(1'b0, 1'b1, 1'b0, 10'h020);
    expectSync("R4 P3 error", 1'b0, 1'b1, 1'b0, 1'b0);
    blank(8);
    check("R8 no samples in vertical blanking", expQ.size(), 0);

    // R5: double errors freeze outputs and set the sticky flag
    sendCode(1'b1, 1'b0, 1'b1, 10'h180);
    expectSync("R5 double flag error", 1'b0, 1'b1, 1'b0, 1'b1);
    blank(2);
    sendCode(1'b1, 1'b1, 1'b1, 10'h048);
    expectSync("R5 flag plus parity error", 1'b0, 1'b1, 1'b0, 1'b1);
    blank(2);
    sendCode(1'b0, 1'b0, 1'b1, 10'h0);
    expectSync("R5 sticky after clean code", 1'b0, 1'b0, 1'b1, 1'b1);
    blank(2);

    // R9: low-bit noise in the preamble
    sendWord(10'h3FC);
    sendWord(10'h000);
    sendWord(10'h000);
    sendWord(xyWord(1'b1, 1'b1, 1'b1));
    expectSync("R9 wide mode rejects", 1'b0, 1'b0, 1'b1, 1'b1);
    blank(2);
    narrowMode = 1'b1;
    sendWord(10'h3FE);
    sendWord(10'h001);
    sendWord(10'h002);
    sendWord(xyWord(1'b1, 1'b1, 1'b1) | 10'h003);
    expectSync("R9 narrow mode accepts", 1'b1, 1'b1, 1'b1, 1'b1);
    blank(2);
    narrowMode = 1'b0;

    // R1: a later reset clears the sticky flag
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check("R1 reset clears flag", {hsyncOut, vsyncOut, fieldOut, codeErr, sampleValid}, 5'b0);
    @(negedge clk);
    rst = 1'b0;
    blank(3);
    check("R6 queue empty at end", expQ.size(), 0);
    finishRun();
  end

endmodule